// File: doc/BRIEF.md
# DMA Channel Event Interrupt Aggregator

This block gathers per-channel event pulses from a multi-channel DMA engine and turns them into a small register view and one interrupt line. It handles three event classes for every channel: block done, transfer done and error. Each class has a sticky raw flag vector, a software-written enable vector, a derived status vector (raw flag and enable both set) and a write-one-to-clear register. An interrupt handler reads the status vectors, clears what it has handled and uses the next-service outputs to pick the next channel without scanning.

The next-service outputs give the lowest-numbered pending channel of the most urgent class. Block-done work is offered first, then transfer-done, then error. The block also keeps a two-state machine per channel. A start pulse takes a channel from IDLE to ACTIVE (transition START). A transfer-done event takes it back to IDLE (transition FINISH). The vector of ACTIVE channels can be read back.

Top module: `dmairq_top`

## Requirements
- R1: An event pulse on a channel of a class sets that channel's raw flag at the next clock edge, and the flag holds until cleared. Raw flags are read at address 0 (block), 1 (transfer) and 2 (error), with bit i for channel i. Clear registers and unmapped addresses read as zero, and writes to read-only addresses change nothing.
- R2: A write to the class clear register clears the raw flag of each channel whose write-data bit is 1. Bits written as 0 leave their flags unchanged. The clear registers are at address 9 (block), 10 (transfer) and 11 (error).
- R3: When an event and a clear reach the same bit in the same cycle, the flag is set after that edge.
- R4: The enable registers are at addresses 3, 4 and 5, in class order. They reset to all zero, meaning every class is masked for every channel, and software can write them and read them back. The status registers at addresses 6, 7 and 8 read raw AND enable. The enables never change the raw flags.
- R5: The summary register at address 12 holds one bit per class: bit 0 block, bit 1 transfer, bit 2 error. A bit is 1 while any status bit of that class is set.
- R6: `irq` is the OR of all status bits, registered. It rises or falls one clock after the status changes.
- R7: Within the class chosen for service, `nxt_ch` is the lowest channel index whose status bit is set.
- R8: The class chosen is block if any block status is set, else transfer, else error. `nxt_cls` encodes 0 = block, 1 = transfer, 2 = error and 3 = nothing pending. `nxt_vld` is low when no status bit is set.
- R9: Each channel has a state machine with states IDLE and ACTIVE. START moves IDLE to ACTIVE on a start pulse. FINISH moves ACTIVE to IDLE on a transfer-done event. A transfer-done event in the same cycle as a start leaves or puts the channel in IDLE. `ch_active` and address 13 show the channels in ACTIVE.
- R10: After reset every raw flag, enable and register read is zero, `irq` and `nxt_vld` are low and all channels are IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_blk | input | NCH | Block-done event pulses, one per channel |
| ev_tfr | input | NCH | Transfer-done event pulses, one per channel |
| ev_err | input | NCH | Error event pulses, one per channel |
| ch_start | input | NCH | Channel start pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on address) |
| irq | output | 1 | Combined interrupt, registered |
| nxt_vld | output | 1 | A channel is pending service |
| nxt_ch | output | CW | Channel to service next |
| nxt_cls | output | 2 | Class of that channel |
| ch_active | output | NCH | Channels in the ACTIVE state |

## Verification
Events, clears, enable writes and start pulses sampled at a rising edge show up in the read data, the next-service outputs and `ch_active` right after that edge. `irq` follows one edge later. The bench drives its stimulus at the falling edge. A behavioural model steps at each rising edge and is compared with every output at the next falling edge, so each result is looked at in the cycle it is due. Directed checks repeat this timing by hand for the masked-after-reset case, the event-and-clear race, the interrupt delay and the class service order.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    // event classes; the value is the service priority (lower first)
    typedef enum logic [1:0] {
        CLS_BLK  = 2'd0,
        CLS_TFR  = 2'd1,
        CLS_ERR  = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;

    localparam int NCLS = 3;

    // per-channel activity states
    typedef enum logic {
        CH_IDLE   = 1'b0,
        CH_ACTIVE = 1'b1
    } ch_state_e;

    // register word addresses; class c sits at base + c
    localparam int A_RAW0  = 0;
    localparam int A_MASK0 = 3;
    localparam int A_STAT0 = 6;
    localparam int A_CLR0  = 9;
    localparam int A_SUM   = 12;
    localparam int A_ACT   = 13;

endpackage

// File: rtl/dmairq_class_bank.sv
module dmairq_class_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] clr,
    input  logic           mask_we,
    input  logic [NCH-1:0] mask_wd,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] mask,
    output logic [NCH-1:0] stat
);

    // sticky flags: a new event wins over a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
        end else begin
            raw <= (raw & ~clr) | evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (mask_we) begin
            mask <= mask_wd;
        end
    end

    assign stat = raw & mask;

    p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt)));

    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~evt)) |=> ((raw & $past(clr & ~evt)) == '0));

    p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|raw) |=> ((($past(raw) & ~$past(clr)) & ~raw) == '0));

    p_race_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & evt)) |=> ((raw & $past(clr & evt)) == $past(clr & evt)));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));

endmodule

// File: rtl/dmairq_chan_fsm.sv
module dmairq_chan_fsm
    import dmairq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] start,
    input  logic [NCH-1:0] done,
    output logic [NCH-1:0] active
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ch_state_e st, st_nx;
        logic      act;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st <= CH_IDLE;
            end else begin
                st <= st_nx;
            end
        end

        always_comb begin
            st_nx = st;
            unique case (st)
                CH_IDLE:   if (start[i] && !done[i]) st_nx = CH_ACTIVE; // START
                CH_ACTIVE: if (done[i])              st_nx = CH_IDLE;   // FINISH
            endcase
        end

        always_comb begin
            act = (st == CH_ACTIVE);
        end

        assign active[i] = act;

        p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
            done[i] |=> !active[i]);

        p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (start[i] && !done[i]) |=> active[i]);
    end

endmodule

// File: rtl/dmairq_lowest.sv
module dmairq_lowest #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] vec,
    output logic           found,
    output logic [CW-1:0]  idx
);

    // scan from the top so the lowest set bit is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = CW'(i);
            end
        end
    end

endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
    import dmairq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 4,
    parameter int DW  = 32,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_blk,
    input  logic [NCH-1:0] ev_tfr,
    input  logic [NCH-1:0] ev_err,
    input  logic [NCH-1:0] ch_start,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           irq,
    output logic           nxt_vld,
    output logic [CW-1:0]  nxt_ch,
    output logic [1:0]     nxt_cls,
    output logic [NCH-1:0] ch_active
);

    logic [NCLS-1:0][NCH-1:0] evt_all, clr_all, raw_all, mask_all, stat_all;
    logic [NCLS-1:0]          mask_we_all, cls_any;
    logic [NCLS-1:0][CW-1:0]  pk_idx;
    cls_e                     sel_cls;
    logic [CW-1:0]            sel_idx;

    assign evt_all[0] = ev_blk;
    assign evt_all[1] = ev_tfr;
    assign evt_all[2] = ev_err;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        assign clr_all[c]     = (reg_we && reg_addr == AW'(A_CLR0 + c)) ? reg_wdata[NCH-1:0] : '0;
        assign mask_we_all[c] = reg_we && (reg_addr == AW'(A_MASK0 + c));

        dmairq_class_bank #(.NCH(NCH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_all[c]),
            .clr     (clr_all[c]),
            .mask_we (mask_we_all[c]),
            .mask_wd (reg_wdata[NCH-1:0]),
            .raw     (raw_all[c]),
            .mask    (mask_all[c]),
            .stat    (stat_all[c])
        );

        dmairq_lowest #(.NCH(NCH), .CW(CW)) u_pick (
            .vec   (stat_all[c]),
            .found (cls_any[c]),
            .idx   (pk_idx[c])
        );
    end

    dmairq_chan_fsm #(.NCH(NCH)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (ch_start),
        .done   (ev_tfr),
        .active (ch_active)
    );

    // class priority: block, then transfer, then error
    always_comb begin
        sel_cls = CLS_NONE;
        sel_idx = '0;
        if (cls_any[0]) begin
            sel_cls = CLS_BLK;
            sel_idx = pk_idx[0];
        end else if (cls_any[1]) begin
            sel_cls = CLS_TFR;
            sel_idx = pk_idx[1];
        end else if (cls_any[2]) begin
            sel_cls = CLS_ERR;
            sel_idx = pk_idx[2];
        end
    end

    assign nxt_vld = (sel_cls != CLS_NONE);
    assign nxt_ch  = sel_idx;
    assign nxt_cls = sel_cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |cls_any;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (reg_addr == AW'(A_RAW0 + c))  reg_rdata[NCH-1:0] = raw_all[c];
            if (reg_addr == AW'(A_MASK0 + c)) reg_rdata[NCH-1:0] = mask_all[c];
            if (reg_addr == AW'(A_STAT0 + c)) reg_rdata[NCH-1:0] = stat_all[c];
        end
        if (reg_addr == AW'(A_SUM)) reg_rdata[NCLS-1:0] = cls_any;
        if (reg_addr == AW'(A_ACT)) reg_rdata[NCH-1:0]  = ch_active;
    end

    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat_all) |=> irq);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|stat_all) |=> !irq);

    p_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_vld == (|stat_all));

    p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_vld && nxt_cls != 2'd0) |-> (stat_all[0] == '0));

    p_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_vld && nxt_cls == 2'd0) |->
            (stat_all[0][nxt_ch] && ((stat_all[0] & ((NCH'(1) << nxt_ch) - NCH'(1))) == '0)));

endmodule

// File: tb/sim_dmairq_top.sv
`timescale 1ns/1ps
module sim_dmairq_top;

    localparam int NCH = 8;
    localparam int AW  = 4;
    localparam int DW  = 32;
    localparam int CW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ev_blk = '0, ev_tfr = '0, ev_err = '0, ch_start = '0;
    logic           reg_we = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic           irq, nxt_vld;
    logic [CW-1:0]  nxt_ch;
    logic [1:0]     nxt_cls;
    logic [NCH-1:0] ch_active;

    always #2 clk = ~clk;   // 250 MHz

    dmairq_top #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_blk(ev_blk), .ev_tfr(ev_tfr), .ev_err(ev_err),
        .ch_start(ch_start), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .nxt_vld(nxt_vld), .nxt_ch(nxt_ch),
        .nxt_cls(nxt_cls), .ch_active(ch_active)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit ended = 0;

    // ---------------- behavioural reference ----------------
    int m_raw  [3][NCH];
    int m_mask [3][NCH];
    int m_act  [NCH];
    int m_irq;

    function automatic int m_anycls(input int c);
        for (int i = 0; i < NCH; i++) if (m_raw[c][i] != 0 && m_mask[c][i] != 0) return 1;
        return 0;
    endfunction

    function automatic int m_vec(input int kind, input int c);
        int v = 0;
        for (int i = 0; i < NCH; i++) begin
            if (kind == 0 && m_raw[c][i] != 0) v |= (1 << i);
            if (kind == 1 && m_mask[c][i] != 0) v |= (1 << i);
            if (kind == 2 && m_raw[c][i] != 0 && m_mask[c][i] != 0) v |= (1 << i);
        end
        return v;
    endfunction

    function automatic int m_actvec();
        int v = 0;
        for (int i = 0; i < NCH; i++) if (m_act[i] != 0) v |= (1 << i);
        return v;
    endfunction

    function automatic int m_read(input int a);
        if (a < 3)  return m_vec(0, a);
        if (a < 6)  return m_vec(1, a - 3);
        if (a < 9)  return m_vec(2, a - 6);
        if (a == 12) return m_anycls(0) | (m_anycls(1) << 1) | (m_anycls(2) << 2);
        if (a == 13) return m_actvec();
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < NCH; i++) begin m_raw[c][i] = 0; m_mask[c][i] = 0; end
            for (int i = 0; i < NCH; i++) m_act[i] = 0;
            m_irq = 0;
        end else begin
            int a;
            m_irq = m_anycls(0) | m_anycls(1) | m_anycls(2);
            a = int'(reg_addr);
            for (int c = 0; c < 3; c++) begin
                for (int i = 0; i < NCH; i++) begin
                    int e;
                    e = (c == 0) ? ev_blk[i] : (c == 1) ? ev_tfr[i] : ev_err[i];
                    if (reg_we && a == 9 + c && reg_wdata[i]) m_raw[c][i] = 0;
                    if (e != 0) m_raw[c][i] = 1;
                    if (reg_we && a == 3 + c) m_mask[c][i] = reg_wdata[i];
                end
            end
            for (int i = 0; i < NCH; i++) begin
                if (ev_tfr[i]) m_act[i] = 0;
                else if (ch_start[i]) m_act[i] = 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic string addr_tag(input int a);
        if (a < 3)  return "R1 raw read";
        if (a < 9)  return "R4 enable/status read";
        if (a == 12) return "R5 summary read";
        if (a == 13) return "R9 active read";
        return "R1 zero read";
    endfunction

    task automatic compare_all();
        int ec, ev, en;
        ev = 0; ec = 3; en = 0;
        for (int c = 2; c >= 0; c--) begin
            for (int i = NCH - 1; i >= 0; i--)
                if (m_raw[c][i] != 0 && m_mask[c][i] != 0) begin ev = 1; ec = c; en = i; end
        end
        chk(int'(irq) == m_irq, "R6 irq", int'(irq), m_irq);
        chk(int'(nxt_vld) == ev, "R8 nxt_vld", int'(nxt_vld), ev);
        chk(int'(nxt_cls) == ec, "R8 nxt_cls", int'(nxt_cls), ec);
        if (ev != 0) chk(int'(nxt_ch) == en, "R7 nxt_ch", int'(nxt_ch), en);
        chk(int'(ch_active) == m_actvec(), "R9 ch_active", int'(ch_active), m_actvec());
        chk(int'(reg_rdata) == m_read(int'(reg_addr)), addr_tag(int'(reg_addr)),
            int'(reg_rdata), m_read(int'(reg_addr)));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        ev_blk = '0; ev_tfr = '0; ev_err = '0; ch_start = '0; reg_we = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
        step();
    endtask

    task automatic peek(input int a, input int exp, input string tag);
        reg_addr = AW'(a);
        #1;
        chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        for (int a = 0; a < 16; a++) peek(a, 0, "R10 reset read");
        chk(irq == 1'b0, "R10 irq", int'(irq), 0);
        chk(nxt_vld == 1'b0, "R10 nxt_vld", int'(nxt_vld), 0);
        chk(nxt_cls == 2'd3, "R10 nxt_cls", int'(nxt_cls), 3);

        // R4 masked after reset: raw set, status and irq stay low
        ev_blk = 8'h08; reg_addr = 0; step();
        peek(0, 8'h08, "R1 raw set");
        peek(6, 0, "R4 masked status");
        step();
        chk(irq == 1'b0, "R4 irq masked", int'(irq), 0);

        // R2 write of zero is ignored, write of one clears
        wr(9, 8'h00); peek(0, 8'h08, "R2 zero write keeps");
        wr(9, 8'h08); peek(0, 8'h00, "R2 one write clears");
        wr(0, 8'hff); peek(0, 8'h00, "R1 raw not writable");

        // R3 event and clear on the same bit
        ev_blk = 8'h04; reg_we = 1'b1; reg_addr = 9; reg_wdata = 8'h04; step();
        peek(0, 8'h04, "R3 event wins");

        // R4 enables readable, R6 irq delay
        wr(3, 8'hff); peek(3, 8'hff, "R4 enable readback");
        chk(irq == 1'b0, "R6 irq one cycle late", int'(irq), 0);
        step();
        chk(irq == 1'b1, "R6 irq raised", int'(irq), 1);
        wr(4, 8'hff); wr(5, 8'hff);

        // R7/R8 order
        ev_blk = 8'h20; ev_tfr = 8'h01; ev_err = 8'h02; step();
        chk(nxt_cls == 2'd0 && nxt_ch == 3'd2, "R8 block first", {nxt_cls, nxt_ch}, {2'd0, 3'd2});
        peek(12, 7, "R5 summary all");
        wr(9, 8'h04);
        chk(nxt_ch == 3'd5, "R7 next lowest", int'(nxt_ch), 5);
        wr(9, 8'h20);
        chk(nxt_cls == 2'd1 && nxt_ch == 3'd0, "R8 transfer next", {nxt_cls, nxt_ch}, {2'd1, 3'd0});
        wr(10, 8'h01);
        chk(nxt_cls == 2'd2 && nxt_ch == 3'd1, "R8 error last", {nxt_cls, nxt_ch}, {2'd2, 3'd1});
        wr(11, 8'hff);
        chk(nxt_vld == 1'b0, "R8 none pending", int'(nxt_vld), 0);
        step();
        chk(irq == 1'b0, "R6 irq dropped", int'(irq), 0);

        // R9 channel state machine
        ch_start = 8'h02; step();
        peek(13, 8'h02, "R9 START");
        ev_tfr = 8'h02; step();
        chk(ch_active == 8'h00, "R9 FINISH", int'(ch_active), 0);
        ch_start = 8'h10; ev_tfr = 8'h10; step();
        chk(ch_active == 8'h00, "R9 done beats start", int'(ch_active), 0);
        wr(10, 8'hff);

        // mixed stimulus against the reference
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 6) == 0) ev_blk = NCH'($urandom);
            if (($urandom % 6) == 0) ev_tfr = NCH'($urandom);
            if (($urandom % 8) == 0) ev_err = NCH'($urandom);
            if (($urandom % 4) == 0) ch_start = NCH'($urandom);
            reg_addr = AW'($urandom % 16);
            if (($urandom % 3) == 0) begin
                reg_we = 1'b1;
                reg_wdata = $urandom;
            end
            step();
        end

        ended = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule